// File: doc/BRIEF.md
# Split-Access 16-bit Prescaled Timer

This block is a 16-bit up-counter that a host with an 8-bit register bus reads and writes one byte at a time. A prescaler in front of the counter divides the count-enable pulses by 1, 2, 4 or 8. A run bit in the control register stops and starts both the prescaler and the counter. A sticky flag records every wrap from 0xFFFF to 0x0000.

The upper counter byte is never written directly. A write to the high address goes into a holding byte. The next write to the low address loads the low byte and moves the holding byte into the upper counter byte in the same clock, so the 16-bit value changes as one. A read of the low byte copies the live upper byte into the holding byte, so a high read that follows returns the upper half that matches the low byte already read. A high-byte write alone leaves the prescaler phase untouched, so the spacing between increments stays the same.

Top module: `tmr16_split`

## Requirements
- R1: After reset the counter, the holding byte and the control register read as 0x00 (timer stopped, ratio 1:1), and the overflow flag is 0.
- R2: Register map on bus_addr: 0 is the counter low byte, 1 is the holding byte, 2 is control, 3 reads 0x00. Control layout: bits [1:0] select the prescale ratio, bit 2 is run, bit 7 reads the overflow flag and the other bits read 0. bus_rdata shows the addressed register combinationally in the cycle bus_re is high.
- R3: A write to address 1 changes only the holding byte. The running counter value is not changed, and the next increment comes in the same cycle it would have come without the write.
- R4: A write to address 0 loads the written byte into the low counter byte and the holding byte into the high counter byte at the same clock edge.
- R5: With ratio select s, the counter advances by one once every 2^s enabled cycles. An enabled cycle is one with run = 1 and cnt_en = 1.
- R6: A write to address 0 restarts the prescaler. No increment happens in the write cycle, and the first increment after it comes on the 2^s-th enabled cycle that follows.
- R7: A read of address 0 copies the current high counter byte into the holding byte.
- R8: An increment from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until a control write with bit 7 = 1 clears it. A control write with bit 7 = 0 leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R9: While run = 0 the counter and the prescaler phase hold, and register writes still take effect.
- R10: Cycles with cnt_en = 0 do not advance the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cnt_en | input | 1 | Count-enable pulse in front of the prescaler |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
A prescaler phase that a high-byte write or a stop disturbs shows up as an increment that comes one or more enabled cycles too early or too late. A low-byte read right after the expected tick shows the wrong value. A holding byte that is not kept separate from the live counter shows up in the first high read after a high write, or in the upper byte of the next low-byte load. A flag that is not sticky shows up at ovf_flag on the enabled cycles that follow the wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    parameter int unsigned TMR_BYTE_W = 8;
    parameter int unsigned TMR_SEL_W  = 2;

    localparam int unsigned TMR_CNT_W    = 2 * TMR_BYTE_W;
    localparam int unsigned TMR_RUN_BIT  = TMR_SEL_W;
    localparam int unsigned TMR_OVF_BIT  = TMR_BYTE_W - 1;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HOLD = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [TMR_BYTE_W-1:0] cnt_hi;
        logic [TMR_BYTE_W-1:0] cnt_lo;
        logic [TMR_BYTE_W-1:0] hold;
        logic                  ovf;
        logic                  run;
        logic [TMR_SEL_W-1:0]  psel;
    } tmr_state_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned PHASE_W = (1 << SEL_W) - 1;

    logic [PHASE_W-1:0] phase_d, phase_q;
    logic [PHASE_W-1:0] limit;

    always_comb begin
        limit   = PHASE_W'((1 << sel) - 1);
        tick    = 1'b0;
        phase_d = phase_q;
        if (restart) begin
            phase_d = '0;
        end else if (step_en) begin
            if (phase_q >= limit) begin
                tick    = 1'b1;
                phase_d = '0;
            end else begin
                phase_d = phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !restart) |=> $stable(phase_q));  // R9
    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));  // R6
    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> step_en);  // R10

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int unsigned BYTE_W = TMR_BYTE_W
) (
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] lo_img,
    input  logic [BYTE_W-1:0] hold_img,
    input  logic [BYTE_W-1:0] ctl_img,
    output logic              wr_lo,
    output logic              wr_hold,
    output logic              wr_ctl,
    output logic              rd_lo,
    output logic [BYTE_W-1:0] rdata
);
    reg_sel_e sel;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        wr_lo   = bus_we && (sel == REG_LO);
        wr_hold = bus_we && (sel == REG_HOLD);
        wr_ctl  = bus_we && (sel == REG_CTL);
        rd_lo   = bus_re && (sel == REG_LO);
        unique case (sel)
            REG_LO:   rdata = lo_img;
            REG_HOLD: rdata = hold_img;
            REG_CTL:  rdata = ctl_img;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr16_split.sv
module tmr16_split
    import tmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [1:0]            bus_addr,
    input  logic [TMR_BYTE_W-1:0] bus_wdata,
    output logic [TMR_BYTE_W-1:0] bus_rdata,
    input  logic                  cnt_en,
    output logic                  ovf_flag
);
    localparam logic [TMR_CNT_W-1:0] CNT_TOP = '1;

    tmr_state_t st_d, st_q;

    logic                  wr_lo, wr_hold, wr_ctl, rd_lo;
    logic                  tick, step_en;
    logic [TMR_BYTE_W-1:0] ctl_img;
    logic [TMR_CNT_W-1:0]  cnt_now, cnt_inc;
    logic                  ovf_set, ovf_clr;

    tmr_bus_decode #(.BYTE_W(TMR_BYTE_W)) u_dec (
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_addr (bus_addr),
        .lo_img   (st_q.cnt_lo),
        .hold_img (st_q.hold),
        .ctl_img  (ctl_img),
        .wr_lo    (wr_lo),
        .wr_hold  (wr_hold),
        .wr_ctl   (wr_ctl),
        .rd_lo    (rd_lo),
        .rdata    (bus_rdata)
    );

    assign step_en = st_q.run && cnt_en;

    tmr_prescale #(.SEL_W(TMR_SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .restart (wr_lo),
        .sel     (st_q.psel),
        .tick    (tick)
    );

    always_comb begin
        ctl_img                   = '0;
        ctl_img[TMR_SEL_W-1:0]    = st_q.psel;
        ctl_img[TMR_RUN_BIT]      = st_q.run;
        ctl_img[TMR_OVF_BIT]      = st_q.ovf;
    end

    always_comb begin
        st_d    = st_q;
        cnt_now = {st_q.cnt_hi, st_q.cnt_lo};
        cnt_inc = cnt_now + 1'b1;
        ovf_set = tick && !wr_lo && (cnt_now == CNT_TOP);
        ovf_clr = wr_ctl && bus_wdata[TMR_OVF_BIT];

        if (tick && !wr_lo) begin
            st_d.cnt_hi = cnt_inc[TMR_CNT_W-1:TMR_BYTE_W];
            st_d.cnt_lo = cnt_inc[TMR_BYTE_W-1:0];
        end
        if (wr_lo) begin
            st_d.cnt_lo = bus_wdata;
            st_d.cnt_hi = st_q.hold;
        end

        if (wr_hold)    st_d.hold = bus_wdata;
        else if (rd_lo) st_d.hold = st_q.cnt_hi;

        if (wr_ctl) begin
            st_d.run  = bus_wdata[TMR_RUN_BIT];
            st_d.psel = bus_wdata[TMR_SEL_W-1:0];
        end

        st_d.ovf = (st_q.ovf && !ovf_clr) || ovf_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_flag = st_q.ovf;

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ({st_q.cnt_hi, st_q.cnt_lo} == {$past(st_q.hold), $past(bus_wdata)}));  // R4
    AST_HOLD_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |=> ({st_q.cnt_hi, st_q.cnt_lo} ==
                     $past({st_q.cnt_hi, st_q.cnt_lo}) + TMR_CNT_W'($past(tick))));  // R3
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_lo) |=> $stable({st_q.cnt_hi, st_q.cnt_lo}));  // R9
    AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_lo) |=> $stable({st_q.cnt_hi, st_q.cnt_lo}));  // R10
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && ({st_q.cnt_hi, st_q.cnt_lo} == CNT_TOP)) |=> ovf_flag);  // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_ctl && bus_wdata[TMR_OVF_BIT])) |=> ovf_flag);  // R8
    AST_RD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !wr_hold) |=> (st_q.hold == $past(st_q.cnt_hi)));  // R7
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hold, wr_ctl}));  // R2

endmodule

// File: tb/tb_tmr16_split.sv
`timescale 1ns/1ps
module tb_tmr16_split;

    typedef struct {
        string      tag;
        logic [7:0] exp;
        bit         is_flag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cnt_en = 1'b0;
    logic       ovf_flag;
    bit         probe = 1'b0;
    bit         done = 1'b0;

    int checks = 0;
    int failures = 0;
    exp_item_t exp_q[$];

    always #4 clk = ~clk;

    tmr16_split dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_en    (cnt_en),
        .ovf_flag  (ovf_flag)
    );

    task automatic step(bit we, bit re, logic [1:0] a, logic [7:0] d, bit en);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; cnt_en = en;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, bit en = 1'b0);
        step(1'b1, 1'b0, a, d, en);
    endtask

    task automatic idle(int n, bit en);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'd0, en);
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
        exp_item_t it;
        it.tag = tag; it.exp = e; it.is_flag = 1'b0;
        exp_q.push_back(it);
        step(1'b0, 1'b1, a, 8'd0, 1'b0);
    endtask

    task automatic chk_flag(bit e, string tag);
        exp_item_t it;
        it.tag = tag; it.exp = {7'd0, e}; it.is_flag = 1'b1;
        exp_q.push_back(it);
        probe = 1'b1;
        step(1'b0, 1'b0, 2'd0, 8'd0, 1'b0);
        probe = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (bus_re || probe) begin
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL monitor: unexpected sample, actual=%02h expected=none", bus_rdata);
                end else begin
                    exp_item_t it;
                    logic [7:0] act;
                    it = exp_q.pop_front();
                    act = it.is_flag ? {7'd0, ovf_flag} : bus_rdata;
                    checks++;
                    if (act !== it.exp) begin
                        failures++;
                        $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        @(negedge clk);
        idle(3, 1'b0);
        rst_n = 1'b1;

        // R1 / R2: reset values and map
        rd(2'd0, 8'h00, "R1 low after reset");
        rd(2'd1, 8'h00, "R1 hold after reset");
        rd(2'd2, 8'h00, "R1 control after reset");
        rd(2'd3, 8'h00, "R2 unused address");
        chk_flag(1'b0, "R1 flag after reset");

        // R4 / R9: atomic load while stopped
        wr(2'd1, 8'h12);
        rd(2'd1, 8'h12, "R3 hold byte written");
        rd(2'd0, 8'h00, "R3 counter low untouched by hold write");
        wr(2'd1, 8'h12);
        wr(2'd0, 8'h34);
        idle(5, 1'b1);
        rd(2'd0, 8'h34, "R9 low held while stopped");
        rd(2'd1, 8'h12, "R4 high loaded from hold");

        // R5 ratio 1:1, R10 enable gating
        wr(2'd2, 8'h04);
        rd(2'd2, 8'h04, "R2 control readback");
        idle(5, 1'b1);
        idle(3, 1'b0);
        rd(2'd0, 8'h39, "R5 ratio 1:1 five steps / R10");
        rd(2'd1, 8'h12, "R7 snapshot of high byte");

        // R5 ratio 1:4
        wr(2'd2, 8'h06);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        idle(7, 1'b1);
        rd(2'd0, 8'h01, "R5 ratio 1:4 after 7 enabled");
        idle(1, 1'b1);
        rd(2'd0, 8'h02, "R5 ratio 1:4 after 8 enabled");

        // R3: hold write does not shift increment timing
        idle(2, 1'b1);
        wr(2'd1, 8'h55, 1'b1);
        idle(1, 1'b1);
        rd(2'd1, 8'h55, "R3 hold keeps written byte");
        rd(2'd0, 8'h03, "R3 increment on schedule");
        rd(2'd1, 8'h00, "R3 R7 counter high unchanged");

        // R6: low write restarts prescaler
        idle(2, 1'b1);
        wr(2'd0, 8'h10, 1'b1);
        idle(3, 1'b1);
        rd(2'd0, 8'h10, "R6 no tick before full ratio");
        idle(1, 1'b1);
        rd(2'd0, 8'h11, "R6 tick after full ratio");

        // R8: wrap flag
        wr(2'd2, 8'h04);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFE);
        idle(1, 1'b1);
        chk_flag(1'b0, "R8 flag clear at FFFF");
        idle(1, 1'b1);
        chk_flag(1'b1, "R8 flag set on wrap");
        rd(2'd2, 8'h84, "R8 flag in control bit 7");
        idle(3, 1'b1);
        chk_flag(1'b1, "R8 flag sticky");
        rd(2'd0, 8'h03, "R8 counter after wrap");
        rd(2'd1, 8'h00, "R8 high byte after wrap");
        wr(2'd2, 8'h04);
        chk_flag(1'b1, "R8 bit7=0 write keeps flag");
        wr(2'd2, 8'h84);
        chk_flag(1'b0, "R8 bit7=1 write clears flag");
        rd(2'd2, 8'h04, "R8 control after clear");

        // R9: stopped counter and prescaler, writes still apply
        wr(2'd2, 8'h00);
        idle(4, 1'b1);
        rd(2'd0, 8'h03, "R9 counter frozen");
        wr(2'd0, 8'h77);
        rd(2'd0, 8'h77, "R9 write applies while stopped");
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h00);
        idle(2, 1'b1);
        wr(2'd2, 8'h02);
        idle(5, 1'b1);
        wr(2'd2, 8'h06);
        idle(1, 1'b1);
        rd(2'd0, 8'h00, "R9 prescaler phase held while stopped");
        idle(1, 1'b1);
        rd(2'd0, 8'h01, "R9 tick after resumed phase");

        idle(3, 1'b0);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule